// File: doc/BRIEF.md
# Serial Bus Byte Interrupt and Clock-Stretch Controller

This block sits beside the shifter of a two-wire serial bus port that can act as bus master or as addressed slave. It watches synchronized samples of the clock and data lines, counts the clock pulses of each byte after a START, and tracks whether the transfer is in its address byte, a receive data byte or a transmit data byte. At a chosen falling clock edge it raises a one-cycle interrupt toward the processor and starts holding the clock line low, so the bus waits until software has dealt with the byte.

The hold point is the ninth falling edge for address bytes. For data bytes a select input picks either the eighth falling edge, before the acknowledge bit, or the ninth, after it. In slave mode the address byte is compared with a programmed 7-bit address; a mismatch makes the block silent until the next START. A first byte that carries the reserved extension prefix is flagged one edge early. Software ends the hold through any of four strobes. The block also drives the acknowledge request for the ninth clock and raises the interrupt when it sees a STOP.

Top module: `i2c_irq_wait_ctrl`

## Requirements
- R1: After reset, and with no bus activity, irq_o, scl_hold_o and ack_drive_o are 0.
- R2: Clock pulses are counted by SCL rising edges after a START (SDA falling while SCL is high); the address byte raises irq_o and scl_hold_o after the 9th falling edge whatever wtim_i is, in master mode always and in slave mode on an address match.
- R3: In a data byte, master or selected slave, wtim_i=0 places the interrupt and hold after the 8th falling edge and wtim_i=1 after the 9th.
- R4: In slave mode (master_i=0) an address byte whose bits 7:1 differ from slave_addr_i, and that is not an extension code, produces no interrupt and no hold for that byte or for any further byte before the next START.
- R5: Address byte layout is bits 7:1 address, bit 0 direction (1 = master reads, slave transmits); on a slave address match, ack_drive_o is 1 from the 8th to the 9th falling edge even when ack_en_i is 0.
- R6: In slave mode, a first byte whose bits 7:3 equal 11110 raises the interrupt and hold after the 8th falling edge instead of the 9th.
- R7: irq_o is a single clock pulse in the cycle the hold starts; scl_hold_o then stays 1 with no gap until a release strobe.
- R8: Any one of wait_rel_i, shift_wr_i, start_req_i or stop_req_i clears scl_hold_o on the next clock edge.
- R9: A STOP (SDA rising while SCL is high) produces a one-cycle irq_o pulse, also for an unaddressed slave.
- R10: Between the 8th and 9th falling edges of a byte that this side receives, ack_drive_o equals ack_en_i as sampled at the 8th falling edge, or as sampled at the release if the hold started at that edge; a transmitting side, and a master on its address byte, keep ack_drive_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| wtim_i | input | 1 | Data-byte hold point: 0 = 8th edge, 1 = 9th edge |
| ack_en_i | input | 1 | Acknowledge enable for received data |
| shift_data_i | input | 8 | Byte held by the shifter, valid from the 8th falling edge |
| slave_addr_i | input | 7 | Own slave address |
| wait_rel_i | input | 1 | Release strobe |
| shift_wr_i | input | 1 | Shifter write strobe, releases the hold |
| start_req_i | input | 1 | START request strobe, releases the hold |
| stop_req_i | input | 1 | STOP request strobe, releases the hold |
| irq_o | output | 1 | Byte/STOP interrupt pulse |
| scl_hold_o | output | 1 | Drive SCL low (clock stretch) |
| ack_drive_o | output | 1 | Drive SDA low as acknowledge during the 9th clock |

## Verification
The hardest case to reach is the early hold on a received byte, where the acknowledge level seen on the bus must come from the enable bit at release time rather than at the edge: the bench enters the 8th-edge hold with ack_en_i at one level, flips it while SCL is held, releases, and only then reads ack_drive_o. Reaching the silent-slave state needs a full address byte with a non-matching address followed by a data byte, so the bench shifts both and confirms no interrupt and no hold appear while the later STOP still interrupts. The extension-code case is reached by shifting the reserved prefix as the first byte in slave mode with wtim_i at 1, so an 8th-edge interrupt can come from that path alone.

// File: rtl/i2c_iw_pkg.sv
package i2c_iw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_RX   = 2'd2,
    PH_TX   = 2'd3
  } phase_e;
endpackage

// File: rtl/i2c_bus_edge.sv
module i2c_bus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_tracker.sv
module i2c_byte_tracker
  import i2c_iw_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned EXT_W    = 5,
  parameter logic [EXT_W-1:0] EXT_CODE = 5'b11110,
  parameter int unsigned CNT_W    = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              master_i,
  input  logic [DATA_W-1:0] shift_data_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output phase_e            phase_o,
  output logic              match_o,
  output logic              ext_o,
  output logic              ext_now_o,
  output logic              ack_win_o
);
  localparam logic [CNT_W-1:0] AT_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] AT_LAST = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_q, next_data;
  logic             match_q, ext_q, rw_q, ack_win_q;
  logic             match_now;

  assign match_now = ~master_i & (shift_data_i[DATA_W-1:1] == slave_addr_i);
  assign ext_now_o = ~master_i & (shift_data_i[DATA_W-1 -: EXT_W] == EXT_CODE);

  always_comb begin
    if (master_i)               next_data = rw_q ? PH_RX : PH_TX;
    else if (match_q || ext_q)  next_data = rw_q ? PH_TX : PH_RX;
    else                        next_data = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      phase_q   <= PH_IDLE;
      match_q   <= 1'b0;
      ext_q     <= 1'b0;
      rw_q      <= 1'b0;
      ack_win_q <= 1'b0;
    end else if (start_i) begin
      cnt_q     <= '0;
      phase_q   <= PH_ADDR;
      match_q   <= 1'b0;
      ext_q     <= 1'b0;
      ack_win_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q     <= '0;
      phase_q   <= PH_IDLE;
      match_q   <= 1'b0;
      ext_q     <= 1'b0;
      ack_win_q <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        if (cnt_q == AT_LAST) begin
          cnt_q <= CNT_W'(1);
          if (phase_q == PH_ADDR) phase_q <= next_data;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (scl_fall_i) begin
        if (cnt_q == AT_DATA) begin
          ack_win_q <= 1'b1;
          if (phase_q == PH_ADDR) begin
            match_q <= match_now & ~ext_now_o;
            ext_q   <= ext_now_o;
            rw_q    <= shift_data_i[0];
          end
        end else if (cnt_q == AT_LAST) begin
          ack_win_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign phase_o   = phase_q;
  assign match_o   = match_q;
  assign ext_o     = ext_q;
  assign ack_win_o = ack_win_q;
endmodule

// File: rtl/i2c_wait_irq.sv
module i2c_wait_irq
  import i2c_iw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_fall_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  phase_e           phase_i,
  input  logic             master_i,
  input  logic             match_i,
  input  logic             ext_i,
  input  logic             ext_now_i,
  input  logic             ack_win_i,
  input  logic             wtim_i,
  input  logic             ack_en_i,
  input  logic             rel_i,
  output logic             irq_o,
  output logic             hold_o,
  output logic             ack_o
);
  localparam logic [CNT_W-1:0] AT_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] AT_LAST = CNT_W'(DATA_W + 1);

  logic at8, at9, fire_pt, fire;
  logic irq_q, hold_q, ack_lat_q;

  assign at8 = (cnt_i == AT_DATA);
  assign at9 = (cnt_i == AT_LAST);

  always_comb begin
    unique case (phase_i)
      PH_ADDR:      fire_pt = master_i ? at9
                                       : ((at8 & ext_now_i) | (at9 & match_i));
      PH_RX, PH_TX: fire_pt = wtim_i ? at9 : at8;
      default:      fire_pt = 1'b0;
    endcase
  end

  assign fire = scl_fall_i & fire_pt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      hold_q    <= 1'b0;
      ack_lat_q <= 1'b0;
    end else begin
      irq_q <= fire | stop_i;
      if (fire)                hold_q <= 1'b1;
      else if (rel_i || stop_i) hold_q <= 1'b0;
      // ack level is fixed at the 8th edge, re-taken when an early hold is released
      if (scl_fall_i && at8)   ack_lat_q <= ack_en_i;
      else if (hold_q && rel_i) ack_lat_q <= ack_en_i;
    end
  end

  assign irq_o  = irq_q;
  assign hold_o = hold_q;
  assign ack_o  = ack_win_i & ((phase_i == PH_ADDR) ? (~master_i & (match_i | (ext_i & ack_lat_q)))
                                                    : ((phase_i == PH_RX) & ack_lat_q));
endmodule

// File: rtl/i2c_irq_wait_ctrl.sv
module i2c_irq_wait_ctrl
  import i2c_iw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = DATA_W - 1,
  parameter int unsigned EXT_W  = 5,
  parameter logic [EXT_W-1:0] EXT_CODE = 5'b11110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              master_i,
  input  logic              wtim_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] shift_data_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              wait_rel_i,
  input  logic              shift_wr_i,
  input  logic              start_req_i,
  input  logic              stop_req_i,
  output logic              irq_o,
  output logic              scl_hold_o,
  output logic              ack_drive_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  logic             scl_rise, scl_fall, start_det, stop_det;
  logic [CNT_W-1:0] cnt;
  phase_e           phase;
  logic             match_q, ext_q, ext_now, ack_win, rel_any;

  assign rel_any = wait_rel_i | shift_wr_i | start_req_i | stop_req_i;

  i2c_bus_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_byte_tracker #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .EXT_W   (EXT_W),
    .EXT_CODE(EXT_CODE),
    .CNT_W   (CNT_W)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .master_i    (master_i),
    .shift_data_i(shift_data_i),
    .slave_addr_i(slave_addr_i),
    .cnt_o       (cnt),
    .phase_o     (phase),
    .match_o     (match_q),
    .ext_o       (ext_q),
    .ext_now_o   (ext_now),
    .ack_win_o   (ack_win)
  );

  i2c_wait_irq #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_fall_i(scl_fall),
    .stop_i    (stop_det),
    .cnt_i     (cnt),
    .phase_i   (phase),
    .master_i  (master_i),
    .match_i   (match_q),
    .ext_i     (ext_q),
    .ext_now_i (ext_now),
    .ack_win_i (ack_win),
    .wtim_i    (wtim_i),
    .ack_en_i  (ack_en_i),
    .rel_i     (rel_any),
    .irq_o     (irq_o),
    .hold_o    (scl_hold_o),
    .ack_o     (ack_drive_o)
  );
endmodule

// File: rtl/i2c_irq_wait_ctrl_chk.sv
module i2c_irq_wait_ctrl_chk
  import i2c_iw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             scl_hold_o,
  input logic             ack_drive_o,
  input logic             master_i,
  input logic             rel_any,
  input logic             scl_fall,
  input logic             stop_det,
  input logic [CNT_W-1:0] cnt,
  input phase_e           phase,
  input logic             match_q,
  input logic             ack_win
);
  // R2
  master_addr_no_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall && master_i && phase == PH_ADDR && cnt == CNT_W'(DATA_W)) |=> !irq_o);

  // R7
  hold_entry_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_o) |-> irq_o);

  // R7
  irq_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R7
  hold_persist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !rel_any && !stop_det) |=> scl_hold_o);

  // R8
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && rel_any) |=> (!scl_hold_o || irq_o));

  // R5
  forced_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_win && phase == PH_ADDR && match_q && !master_i) |-> ack_drive_o);

  // R9
  stop_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> irq_o);
endmodule

bind i2c_irq_wait_ctrl i2c_irq_wait_ctrl_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .scl_hold_o (scl_hold_o),
  .ack_drive_o(ack_drive_o),
  .master_i   (master_i),
  .rel_any    (rel_any),
  .scl_fall   (scl_fall),
  .stop_det   (stop_det),
  .cnt        (cnt),
  .phase      (phase),
  .match_q    (match_q),
  .ack_win    (ack_win)
);

// File: tb/i2c_irq_wait_ctrl_tb.sv
module i2c_irq_wait_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       master = 1'b0, wtim = 1'b0, ack_en = 1'b0;
  logic [7:0] shift_data = '0;
  logic [6:0] slave_addr = 7'h3A;
  logic       wait_rel = 1'b0, shift_wr = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic       irq, hold, ack_drv;

  int    n_cmp = 0, n_bad = 0;
  int    cur_tag = 0, byte_no = 0;
  int    exp_q[$];
  string req_q[$];
  bit    done = 1'b0;

  always #2 clk = ~clk;

  i2c_irq_wait_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .master_i(master), .wtim_i(wtim), .ack_en_i(ack_en),
    .shift_data_i(shift_data), .slave_addr_i(slave_addr),
    .wait_rel_i(wait_rel), .shift_wr_i(shift_wr),
    .start_req_i(start_req), .stop_req_i(stop_req),
    .irq_o(irq), .scl_hold_o(hold), .ack_drive_o(ack_drv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (byte %0d)", req, act, exp, byte_no);
    end
  endtask

  // monitor: every interrupt must match the next expected item
  always @(negedge clk) begin
    if (rst_n && irq && !done) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R4: unexpected interrupt, actual tag %0d expected none", cur_tag);
      end else begin
        int    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (e != cur_tag) begin
          n_bad++;
          $display("FAIL %s: interrupt at tag %0d expected %0d", r, cur_tag, e);
        end
      end
    end
  end

  task automatic expect_irq(input int tag, input string req);
    exp_q.push_back(tag);
    req_q.push_back(req);
  endtask

  task automatic release_hold(input int how);
    case (how)
      0: wait_rel = 1'b1;
      1: shift_wr = 1'b1;
      2: start_req = 1'b1;
      default: stop_req = 1'b1;
    endcase
    tick(1);
    wait_rel = 1'b0; shift_wr = 1'b0; start_req = 1'b0; stop_req = 1'b0;
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; tick(3);
    sda = 1'b0; tick(3);
    scl = 1'b0; tick(3);
  endtask

  task automatic bus_stop();
    sda = 1'b0; tick(2);
    scl = 1'b1; tick(3);
    cur_tag = 999;
    expect_irq(999, "R9");
    sda = 1'b1; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] val, input int fire_at, input int how,
                           input logic ack_fall, input logic ack_rel, input logic exp_ack,
                           input string req);
    shift_data = val;
    ack_en = ack_fall;
    for (int k = 1; k <= 9; k++) begin
      sda = (k <= 8) ? val[8-k] : 1'b1;
      tick(2);
      scl = 1'b1; tick(3);
      cur_tag = byte_no * 16 + k;
      if (k == fire_at) expect_irq(cur_tag, req);
      scl = 1'b0; tick(3);
      if (k == fire_at) begin
        chk({req, " R7 hold entered"}, hold, 1'b1);
        tick(5);
        chk("R7 hold kept", hold, 1'b1);
        ack_en = ack_rel;
        release_hold(how);
        tick(1);
        chk("R8 hold released", hold, 1'b0);
      end else if (k >= 8) begin
        chk({req, " no hold"}, hold, 1'b0);
      end
      if (k == 8) chk({req, " R10 ack level"}, ack_drv, exp_ack);
    end
    byte_no++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 hold reset", hold, 1'b0);
    chk("R1 ack reset", ack_drv, 1'b0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 idle irq", irq, 1'b0);

    // master write, 8-edge data hold
    master = 1'b1; wtim = 1'b0;
    bus_start();
    send_byte(8'hA0, 9, 0, 1'b0, 1'b0, 1'b0, "R2");
    send_byte(8'h55, 8, 1, 1'b1, 1'b1, 1'b0, "R3");
    wtim = 1'b1;
    send_byte(8'h33, 9, 2, 1'b0, 1'b0, 1'b0, "R3");
    bus_stop();

    // master read, 9-edge then 8-edge hold
    bus_start();
    send_byte(8'hA1, 9, 3, 1'b1, 1'b1, 1'b0, "R2");
    send_byte(8'h0F, 9, 0, 1'b1, 1'b1, 1'b1, "R10");
    wtim = 1'b0;
    send_byte(8'hF0, 8, 0, 1'b0, 1'b1, 1'b1, "R10");
    bus_stop();

    // slave write, address match with ack enable off
    master = 1'b0; wtim = 1'b0;
    bus_start();
    send_byte(8'h74, 9, 0, 1'b0, 1'b0, 1'b1, "R5");
    send_byte(8'h12, 8, 1, 1'b1, 1'b0, 1'b0, "R10");
    wtim = 1'b1;
    send_byte(8'h34, 9, 0, 1'b1, 1'b1, 1'b1, "R3");
    bus_stop();

    // slave, other address: silent until STOP
    wtim = 1'b0;
    bus_start();
    send_byte(8'h76, 0, 0, 1'b1, 1'b1, 1'b0, "R4");
    send_byte(8'h12, 0, 0, 1'b1, 1'b1, 1'b0, "R4");
    bus_stop();

    // slave, extension prefix
    wtim = 1'b1;
    bus_start();
    send_byte(8'hF0, 8, 0, 1'b1, 1'b1, 1'b1, "R6");
    bus_stop();

    // slave read: forced ack on address, none when transmitting
    wtim = 1'b1;
    bus_start();
    send_byte(8'h75, 9, 0, 1'b0, 1'b0, 1'b1, "R5");
    wtim = 1'b0;
    send_byte(8'hAA, 8, 2, 1'b1, 1'b1, 1'b0, "R10");
    bus_stop();

    tick(10);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: actual %0d interrupts missing expected 0", exp_q.size());
    end
    chk("R1 final hold", hold, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule